// File: doc/BRIEF.md
# Configuration PROM readout controller

This block is the read path of a configuration memory that feeds a stored bitstream to an FPGA. It keeps a byte address and a bit index into an internal image store. On each qualified configuration clock tick it moves forward by one bit in serial mode or by one byte in 8-bit parallel mode. The tick comes either from an external clock-enable strobe or from an internal oscillator strobe. A control input picks which one.

Three inputs can hold the read position at zero: the chip-enable input, the active-low output-enable/reset input and the active-low config pulse. While the chip-enable input is high or the output-enable/reset input is low, all outputs are high-impedance. The config pulse clears the position but leaves the outputs driven. The rising edge of the config pulse captures a 2-bit revision number. This number forms the upper address bits, so it chooses one of four stored images.

Tri-state is modelled with one enable output per data pin and one for the clock output. There are no bidirectional nets.

Top module: `cfg_prom_reader`

## Requirements
- R1: At a clock edge the read position moves forward only when the selected tick is high, `ce_n_i` is 0, `oe_rst_n_i` is 1, `cf_n_i` is 1 and, in parallel mode only, `busy_i` is 0. Otherwise it holds.
- R2: `clk_sel_i` = 0 selects `ext_tick_i` as the tick. `clk_sel_i` = 1 selects `osc_tick_i`. The tick that is not selected has no effect.
- R3: While `oe_rst_n_i` is 0, the read position is cleared to byte 0 and bit 0, and all enables in `d_oe_o` and `clkout_oe_o` are 0.
- R4: While `ce_n_i` is 1, the read position is cleared, and all of `d_oe_o` and `clkout_oe_o` are 0.
- R5: While `cf_n_i` is 0, the read position is cleared, but the outputs stay driven when chip enable and output enable are active.
- R6: A 0-to-1 transition of `cf_n_i` captures `rev_sel_i` as the image number, which forms the upper 2 bits of the image address. `rev_sel_i` has no effect at any other time.
- R7: Serial mode (`par_mode_i` = 0) behaves as follows. `d_oe_o` is 8'h01 when driven. `d_o[0]` carries the current byte most significant bit first, one bit per tick. The byte address advances after the eighth bit. `busy_i` is ignored.
- R8: Parallel mode (`par_mode_i` = 1) behaves as follows. `d_oe_o` is 8'hFF when driven, and `d_o` is the whole byte. The byte for image r and byte address a (4 bits) equals ((r*16 + a)*29 + 53) mod 256.
- R9: At the last byte address of an image (15), the position stops and does not wrap. In serial mode it stops on the final bit of that byte.
- R10: `clkout_o` equals the selected tick while the outputs are driven. `clkout_oe_o` is 1 exactly while `ce_n_i` is 0 and `oe_rst_n_i` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Block clock |
| rst_n_i | input | 1 | Power-on reset, active low |
| clk_sel_i | input | 1 | Tick source select (0 external, 1 oscillator) |
| ext_tick_i | input | 1 | External configuration clock strobe |
| osc_tick_i | input | 1 | Internal oscillator strobe |
| ce_n_i | input | 1 | Chip enable, active low |
| oe_rst_n_i | input | 1 | Output enable / position reset, active low |
| cf_n_i | input | 1 | Config pulse, active low |
| busy_i | input | 1 | Parallel-mode hold from the FPGA |
| par_mode_i | input | 1 | 1 = 8-bit parallel, 0 = serial |
| rev_sel_i | input | 2 | Image number captured on the rising edge of the config pulse |
| d_o | output | 8 | Data pin values |
| d_oe_o | output | 8 | Per-pin drive enables |
| clkout_o | output | 1 | Clock output |
| clkout_oe_o | output | 1 | Clock output drive enable |

## Verification
Some properties are checked on every cycle. The clear paths empty the position one cycle later. With no tick the position holds. The disabled outputs release every pin. Serial mode drives only pin 0. The image number changes only after a rising config edge. The last address is never passed. The scenarios are needed for the rest: the exact byte values, the bit order in serial mode, the choice between the two tick sources and the effect of the busy input in each mode. The scenarios compare the pins with a model built from the requirements.

// File: rtl/cfgp_pkg.sv
package cfgp_pkg;
   localparam int BYTE_W    = 8;
   localparam int BIT_IDX_W = $clog2(BYTE_W);
   localparam int REV_W     = 2;
   typedef logic [BYTE_W-1:0] byte_t;
endpackage

// File: rtl/cfgp_addr_ctr.sv
module cfgp_addr_ctr
   import cfgp_pkg::*;
#(
   parameter int ADDR_W = 4
) (
   input  logic                 clk_i,
   input  logic                 rst_n_i,
   input  logic                 clr_i,
   input  logic                 adv_i,
   input  logic                 par_mode_i,
   output logic [ADDR_W-1:0]    byte_addr_o,
   output logic [BIT_IDX_W-1:0] bit_idx_o
);
   localparam logic [ADDR_W-1:0]    LAST_ADDR = {ADDR_W{1'b1}};
   localparam logic [BIT_IDX_W-1:0] LAST_BIT  = {BIT_IDX_W{1'b1}};

   logic at_last;
   assign at_last = (byte_addr_o == LAST_ADDR);

   always_ff @(posedge clk_i or negedge rst_n_i) begin
      if (!rst_n_i) begin
         byte_addr_o <= '0;
         bit_idx_o   <= '0;
      end else if (clr_i) begin
         byte_addr_o <= '0;
         bit_idx_o   <= '0;
      end else if (adv_i) begin
         if (par_mode_i) begin
            bit_idx_o <= '0;
            if (!at_last) byte_addr_o <= byte_addr_o + 1'b1;
         end else if (bit_idx_o == LAST_BIT) begin
            if (!at_last) begin
               byte_addr_o <= byte_addr_o + 1'b1;
               bit_idx_o   <= '0;
            end
         end else begin
            bit_idx_o <= bit_idx_o + 1'b1;
         end
      end
   end
endmodule

// File: rtl/cfgp_rev_latch.sv
module cfgp_rev_latch
   import cfgp_pkg::*;
(
   input  logic             clk_i,
   input  logic             rst_n_i,
   input  logic             cf_n_i,
   input  logic [REV_W-1:0] rev_sel_i,
   output logic [REV_W-1:0] rev_o
);
   logic cf_prev;

   always_ff @(posedge clk_i or negedge rst_n_i) begin
      if (!rst_n_i) begin
         cf_prev <= 1'b1;
         rev_o   <= '0;
      end else begin
         cf_prev <= cf_n_i;
         if (cf_n_i && !cf_prev) rev_o <= rev_sel_i;
      end
   end
endmodule

// File: rtl/cfgp_image_rom.sv
module cfgp_image_rom
   import cfgp_pkg::*;
#(
   parameter int ADDR_W = 4,
   parameter int MULT   = 29,
   parameter int OFFS   = 53
) (
   input  logic [REV_W-1:0]  rev_i,
   input  logic [ADDR_W-1:0] addr_i,
   output byte_t             data_o
);
   localparam int FULL_W = REV_W + ADDR_W;
   localparam int PROD_W = FULL_W + 16;

   logic [PROD_W-1:0] prod;
   assign prod   = PROD_W'({rev_i, addr_i}) * PROD_W'(MULT) + PROD_W'(OFFS);
   assign data_o = prod[BYTE_W-1:0];
endmodule

// File: rtl/cfgp_out_drive.sv
module cfgp_out_drive
   import cfgp_pkg::*;
(
   input  logic                 drive_i,
   input  logic                 par_mode_i,
   input  logic                 tick_i,
   input  byte_t                data_i,
   input  logic [BIT_IDX_W-1:0] bit_idx_i,
   output byte_t                d_o,
   output byte_t                d_oe_o,
   output logic                 clkout_o,
   output logic                 clkout_oe_o
);
   logic ser_bit;
   assign ser_bit = data_i[(BYTE_W-1) - int'(bit_idx_i)];

   for (genvar gi = 0; gi < BYTE_W; gi++) begin : g_pin
      if (gi == 0) begin : g_lead
         assign d_o[gi]    = drive_i & (par_mode_i ? data_i[gi] : ser_bit);
         assign d_oe_o[gi] = drive_i;
      end else begin : g_wide
         assign d_o[gi]    = drive_i & par_mode_i & data_i[gi];
         assign d_oe_o[gi] = drive_i & par_mode_i;
      end
   end

   assign clkout_o    = drive_i & tick_i;
   assign clkout_oe_o = drive_i;
endmodule

// File: rtl/cfg_prom_reader.sv
module cfg_prom_reader
   import cfgp_pkg::*;
#(
   parameter int ADDR_W = 4,
   parameter int MULT   = 29,
   parameter int OFFS   = 53
) (
   input  logic             clk_i,
   input  logic             rst_n_i,
   input  logic             clk_sel_i,
   input  logic             ext_tick_i,
   input  logic             osc_tick_i,
   input  logic             ce_n_i,
   input  logic             oe_rst_n_i,
   input  logic             cf_n_i,
   input  logic             busy_i,
   input  logic             par_mode_i,
   input  logic [REV_W-1:0] rev_sel_i,
   output logic [7:0]       d_o,
   output logic [7:0]       d_oe_o,
   output logic             clkout_o,
   output logic             clkout_oe_o
);
   if (ADDR_W < 1 || ADDR_W > 24) begin : g_bad_addr_w
      $error("cfg_prom_reader: ADDR_W out of range");
   end
   if (BYTE_W != 8) begin : g_bad_byte_w
      $error("cfg_prom_reader: byte width must be 8");
   end

   logic                 sel_tick;
   logic                 clr;
   logic                 drive;
   logic                 adv;
   logic [ADDR_W-1:0]    byte_addr;
   logic [BIT_IDX_W-1:0] bit_idx;
   logic [REV_W-1:0]     rev_q;
   byte_t                rom_data;

   assign sel_tick = clk_sel_i ? osc_tick_i : ext_tick_i;
   assign clr      = ce_n_i | ~oe_rst_n_i | ~cf_n_i;
   assign drive    = ~ce_n_i & oe_rst_n_i;
   assign adv      = sel_tick & ~clr & (~par_mode_i | ~busy_i);

   cfgp_addr_ctr #(.ADDR_W(ADDR_W)) u_ctr (
      .clk_i      (clk_i),
      .rst_n_i    (rst_n_i),
      .clr_i      (clr),
      .adv_i      (adv),
      .par_mode_i (par_mode_i),
      .byte_addr_o(byte_addr),
      .bit_idx_o  (bit_idx)
   );

   cfgp_rev_latch u_rev (
      .clk_i    (clk_i),
      .rst_n_i  (rst_n_i),
      .cf_n_i   (cf_n_i),
      .rev_sel_i(rev_sel_i),
      .rev_o    (rev_q)
   );

   cfgp_image_rom #(.ADDR_W(ADDR_W), .MULT(MULT), .OFFS(OFFS)) u_rom (
      .rev_i (rev_q),
      .addr_i(byte_addr),
      .data_o(rom_data)
   );

   cfgp_out_drive u_drv (
      .drive_i    (drive),
      .par_mode_i (par_mode_i),
      .tick_i     (sel_tick),
      .data_i     (rom_data),
      .bit_idx_i  (bit_idx),
      .d_o        (d_o),
      .d_oe_o     (d_oe_o),
      .clkout_o   (clkout_o),
      .clkout_oe_o(clkout_oe_o)
   );
endmodule

// File: rtl/cfgp_checker.sv
module cfgp_checker
   import cfgp_pkg::*;
#(
   parameter int ADDR_W = 4
) (
   input logic                 clk_i,
   input logic                 rst_n_i,
   input logic                 ce_n_i,
   input logic                 oe_rst_n_i,
   input logic                 cf_n_i,
   input logic                 busy_i,
   input logic                 par_mode_i,
   input logic                 sel_tick,
   input logic [ADDR_W-1:0]    byte_addr,
   input logic [BIT_IDX_W-1:0] bit_idx,
   input logic [REV_W-1:0]     rev_q,
   input logic [7:0]           d_oe_o,
   input logic                 clkout_oe_o
);
   localparam logic [ADDR_W-1:0] LAST_ADDR = {ADDR_W{1'b1}};

   AST_CLEAR_ON_HOLD: assert property (@(posedge clk_i) disable iff (!rst_n_i)
      (ce_n_i || !oe_rst_n_i || !cf_n_i) |=> (byte_addr == '0 && bit_idx == '0)); // R5

   AST_HOLD_NO_TICK: assert property (@(posedge clk_i) disable iff (!rst_n_i)
      (!sel_tick && ce_n_i == 1'b0 && oe_rst_n_i && cf_n_i) |=> ($stable(byte_addr) && $stable(bit_idx))); // R1

   AST_BUSY_PAR_HOLD: assert property (@(posedge clk_i) disable iff (!rst_n_i)
      (par_mode_i && busy_i && !ce_n_i && oe_rst_n_i && cf_n_i) |=> $stable(byte_addr)); // R1

   AST_RELEASE_ON_OFF: assert property (@(posedge clk_i) disable iff (!rst_n_i)
      (ce_n_i || !oe_rst_n_i) |-> (d_oe_o == 8'h00 && !clkout_oe_o)); // R3

   AST_SERIAL_ONE_PIN: assert property (@(posedge clk_i) disable iff (!rst_n_i)
      (!ce_n_i && oe_rst_n_i && !par_mode_i) |-> (d_oe_o == 8'h01)); // R7

   AST_REV_ONLY_ON_RISE: assert property (@(posedge clk_i) disable iff (!rst_n_i)
      !(cf_n_i && !$past(cf_n_i)) |=> $stable(rev_q)); // R6

   AST_NO_WRAP: assert property (@(posedge clk_i) disable iff (!rst_n_i)
      (byte_addr == LAST_ADDR && !ce_n_i && oe_rst_n_i && cf_n_i) |=> (byte_addr == LAST_ADDR)); // R9
endmodule

bind cfg_prom_reader cfgp_checker #(.ADDR_W(ADDR_W)) u_chk (
   .clk_i      (clk_i),
   .rst_n_i    (rst_n_i),
   .ce_n_i     (ce_n_i),
   .oe_rst_n_i (oe_rst_n_i),
   .cf_n_i     (cf_n_i),
   .busy_i     (busy_i),
   .par_mode_i (par_mode_i),
   .sel_tick   (sel_tick),
   .byte_addr  (byte_addr),
   .bit_idx    (bit_idx),
   .rev_q      (rev_q),
   .d_oe_o     (d_oe_o),
   .clkout_oe_o(clkout_oe_o)
);

// File: tb/tb_cfg_prom_reader.sv
`timescale 1ns/100ps
module tb_cfg_prom_reader;
   logic       clk_i = 1'b0;
   logic       rst_n_i = 1'b0;
   logic       clk_sel_i = 1'b0, ext_tick_i = 1'b0, osc_tick_i = 1'b0;
   logic       ce_n_i = 1'b1, oe_rst_n_i = 1'b1, cf_n_i = 1'b1, busy_i = 1'b0;
   logic       par_mode_i = 1'b1;
   logic [1:0] rev_sel_i = 2'd0;
   logic [7:0] d_o, d_oe_o;
   logic       clkout_o, clkout_oe_o;

   int checks = 0;
   int errors = 0;
   int m_addr = 0;
   int m_rev  = 0;

   always #2.5 clk_i = ~clk_i;

   cfg_prom_reader dut (.*);

   function automatic logic [7:0] img(input int r, input int a);
      int v;
      v = ((r * 16 + a) * 29 + 53) % 256;
      return v[7:0];
   endfunction

   task automatic chk(input logic ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic cyc();
      @(posedge clk_i);
      #1;
   endtask

   // vector fields: [6]ce_n [5]oe_rst_n [4]cf_n [3]busy [2]clk_sel [1]ext [0]osc
   localparam int NV = 13;
   localparam logic [6:0] VEC [NV] = '{
      7'b0110010, // R1 advance on external tick
      7'b0110010, // R1 advance again
      7'b0111010, // R1 busy holds in parallel
      7'b0110000, // R1 no tick holds
      7'b0110101, // R2 oscillator selected
      7'b0110110, // R2 unselected external tick ignored
      7'b0100010, // R5 cf low clears, still driven
      7'b0110010, // R1 advance after cf release
      7'b0000010, // R3 oe low clears and releases
      7'b0110010, // R1
      7'b1110010, // R4 ce high clears and releases
      7'b0110010, // R1
      7'b0110100  // R2 oscillator low, external ignored
   };

   initial begin : main
      cyc();
      rst_n_i = 1'b1;
      cyc();
      chk(d_oe_o == 8'h00 && !clkout_oe_o, "R4 reset/standby", d_oe_o, 0);

      ce_n_i = 1'b0; oe_rst_n_i = 1'b1; cf_n_i = 1'b1; par_mode_i = 1'b1;
      cyc();
      chk(d_oe_o == 8'hFF, "R8 parallel enables", d_oe_o, 8'hFF);
      chk(d_o == img(0, 0), "R8 first byte", d_o, img(0, 0));

      for (int i = 0; i < NV; i++) begin
         logic tk, clr, drv;
         {ce_n_i, oe_rst_n_i, cf_n_i, busy_i, clk_sel_i, ext_tick_i, osc_tick_i} = VEC[i];
         tk  = clk_sel_i ? osc_tick_i : ext_tick_i;
         clr = ce_n_i | ~oe_rst_n_i | ~cf_n_i;
         drv = ~ce_n_i & oe_rst_n_i;
         if (clr) m_addr = 0;
         else if (tk && !busy_i && m_addr < 15) m_addr++;
         cyc();
         chk(d_oe_o == (drv ? 8'hFF : 8'h00), "R3/R4 vector enables", d_oe_o, drv ? 8'hFF : 8'h00);
         chk(clkout_oe_o == drv && clkout_o == (drv & tk), "R10 clock out", {clkout_oe_o, clkout_o}, {drv, drv & tk});
         if (drv) chk(d_o == img(m_rev, m_addr), "R1/R2/R5 vector byte", d_o, img(m_rev, m_addr));
      end

      // serial mode, busy ignored
      {ce_n_i, oe_rst_n_i, busy_i, clk_sel_i, ext_tick_i, osc_tick_i} = 6'b010000;
      cf_n_i = 1'b0; cyc(); cf_n_i = 1'b1; cyc();
      par_mode_i = 1'b0; busy_i = 1'b1;
      cyc();
      for (int i = 0; i < 16; i++) begin
         logic [7:0] b;
         b = img(0, i / 8);
         chk(d_oe_o == 8'h01, "R7 serial enables", d_oe_o, 1);
         chk(d_o[0] == b[7 - (i % 8)], "R7 serial bit order", d_o[0], b[7 - (i % 8)]);
         ext_tick_i = 1'b1; cyc(); ext_tick_i = 1'b0;
      end

      // revision capture
      rev_sel_i = 2'd2; cf_n_i = 1'b0; cyc();
      cf_n_i = 1'b1; cyc();
      rev_sel_i = 2'd1; cyc(); cyc();
      par_mode_i = 1'b1; busy_i = 1'b0;
      #1;
      chk(d_o == img(2, 0), "R6 revision captured on rise", d_o, img(2, 0));

      // stop at last address
      ext_tick_i = 1'b1;
      for (int i = 0; i < 20; i++) cyc();
      chk(d_o == img(2, 15), "R9 stop at last", d_o, img(2, 15));
      cyc();
      chk(d_o == img(2, 15), "R9 no wrap", d_o, img(2, 15));

      // serial stop on final bit of the last byte
      par_mode_i = 1'b0;
      for (int i = 0; i < 12; i++) cyc();
      begin
         logic [7:0] lb;
         lb = img(2, 15);
         chk(d_o[0] == lb[0], "R9 serial holds last bit", d_o[0], lb[0]);
      end
      ext_tick_i = 1'b0;

      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin : watchdog
      #500000;
      errors++;
      checks++;
      $display("FAIL watchdog expired actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule